// File: doc/BRIEF.md
# Exception Entry Cycle Sequencer

This block reproduces, cycle by cycle, the bus activity of a 16-bit processor core while it enters an exception. A request names the exception class and selects one of two core variants, the base core or the extended-frame core. The sequencer then runs through three phases. First come a number of idle cycles that depends on the class. Then three stacking writes go out on a valid/ready stream. Last come the fixed cycles that remain until the class's total entry time is reached. Each write carries a kind code and the stack address it targets.

The write stream follows the usual back-pressure rules. The sequencer raises `wr_valid` with a kind and an address. Those values stay frozen until a rising edge sees `wr_ready` high, and that edge completes the transfer. Every cycle in which `wr_valid` is high and `wr_ready` is low counts as a stall. Stall cycles lengthen the sequence but are counted apart from the nominal count. While a sequence runs, `busy` is high and new requests are not taken. When the sequence finishes, `done` pulses and both counts are presented.

Top module: `exc_entry_seq`

## Requirements
- R1: After a request is accepted, `wr_valid` stays low for a class-dependent number of idle cycles and then goes high. The class codes are 2 bus error, 3 address error, 4 illegal instruction, 5 divide by zero and 7 trap-on-overflow. The idle counts are 12 for bus error, 8 for address error, 0 for trap-on-overflow and 4 for every other class.
- R2: The three stack writes complete in a fixed order. First is the PC low word (`wr_kind` 0), then the status register (`wr_kind` 1), then the PC high word (`wr_kind` 2).
- R3: The write addresses are the captured stack pointer minus 2, minus 4 and minus 6, in write order.
- R4: On the base variant (`req_ext`=0) the reported nominal count is 58 for bus error, 54 for address error, 34 for illegal instruction and 34 for divide by zero.
- R5: On the extended-frame variant (`req_ext`=1) the reported nominal count is 134 for bus error, 130 for address error, 38 for illegal instruction and 38 for divide by zero.
- R6: Any other class code (0, 1, 6), and trap-on-overflow (7), reports 34 on the base variant and 38 on the extended variant. Codes 0, 1 and 6 use the 4-cycle idle preamble.
- R7: A request is accepted only when `busy` is low. A request raised while `busy` is high has no effect on the running sequence's writes or counts, and no further sequence starts after it is withdrawn.
- R8: While `wr_valid` is high and `wr_ready` is low, `wr_valid`, `wr_kind` and `wr_addr` hold. Each such cycle adds one to `stall_cycles`. `busy` stays high for the nominal count plus the stall count.
- R9: `done` is a one-cycle pulse in the cycle right after `busy` falls. `nominal_cycles` and `stall_cycles` keep their values until the next request is accepted.
- R10: After reset, `busy`, `wr_valid` and `done` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Exception request |
| req_class | input | 3 | Exception class code |
| req_ext | input | 1 | 1 selects the extended-frame variant |
| req_sp | input | AW | Stack pointer at entry |
| busy | output | 1 | Sequence in progress; requests are ignored |
| wr_valid | output | 1 | Stack write offered |
| wr_ready | input | 1 | Stack write accepted |
| wr_kind | output | 2 | 0 PC low, 1 status register, 2 PC high |
| wr_addr | output | AW | Stack write address |
| done | output | 1 | One-cycle end-of-sequence pulse |
| nominal_cycles | output | CW | Entry length without stalls |
| stall_cycles | output | SW | Cycles lost to write back-pressure |

## Verification
The hardest case to reach from the ports is a new request that overlaps a running sequence while the write stream is also under back-pressure. To create it, the bench holds `wr_ready` low for a set number of cycles at every write. In the same run it raises and then drops a request with a different class and stack pointer in the middle of the sequence. It then checks that the idle count, the write addresses, the nominal total and the stall count all belong to the first request, and that no second sequence follows.

// File: rtl/exc_seq_pkg.sv
package exc_seq_pkg;
  localparam logic [2:0] CLS_BUS   = 3'd2;
  localparam logic [2:0] CLS_ADDR  = 3'd3;
  localparam logic [2:0] CLS_ILL   = 3'd4;
  localparam logic [2:0] CLS_DIV0  = 3'd5;
  localparam logic [2:0] CLS_TRAPV = 3'd7;

  localparam logic [1:0] WK_PC_LO = 2'd0;
  localparam logic [1:0] WK_SR    = 2'd1;
  localparam logic [1:0] WK_PC_HI = 2'd2;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_PRE  = 2'd1,
    ST_WR   = 2'd2,
    ST_TAIL = 2'd3
  } seq_state_e;
endpackage

// File: rtl/exc_class_decode.sv
module exc_class_decode
  import exc_seq_pkg::*;
#(
  parameter int CW = 8
) (
  input  logic [2:0]    cls,
  input  logic          ext,
  output logic [CW-1:0] offset,
  output logic [CW-1:0] total
);
  always_comb begin
    case (cls)
      CLS_BUS:   offset = CW'(12);
      CLS_ADDR:  offset = CW'(8);
      CLS_TRAPV: offset = CW'(0);
      default:   offset = CW'(4);
    endcase
    case (cls)
      CLS_BUS:  total = ext ? CW'(134) : CW'(58);
      CLS_ADDR: total = ext ? CW'(130) : CW'(54);
      default:  total = ext ? CW'(38)  : CW'(34);
    endcase
    // R4
    tail_room_chk: assert (total >= offset + CW'(4));
  end
endmodule

// File: rtl/exc_cycle_meter.sv
module exc_cycle_meter #(
  parameter int CW = 8,
  parameter int SW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          tick,
  input  logic          stall,
  input  logic          finish,
  output logic [CW-1:0] nominal,
  output logic [SW-1:0] stalls
);
  logic [CW-1:0] nom_cnt;
  logic [SW-1:0] stl_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      nom_cnt <= '0;
      stl_cnt <= '0;
      nominal <= '0;
      stalls  <= '0;
    end else begin
      if (start) begin
        nom_cnt <= '0;
        stl_cnt <= '0;
      end else begin
        if (tick)  nom_cnt <= nom_cnt + CW'(1);
        if (stall) stl_cnt <= stl_cnt + SW'(1);
      end
      if (finish) begin
        nominal <= nom_cnt + CW'(1);
        stalls  <= stl_cnt;
      end
    end
  end

  // R8
  tick_stall_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(tick && stall));
endmodule

// File: rtl/exc_entry_seq.sv
module exc_entry_seq
  import exc_seq_pkg::*;
#(
  parameter int AW = 32,
  parameter int CW = 8,
  parameter int SW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic [2:0]    req_class,
  input  logic          req_ext,
  input  logic [AW-1:0] req_sp,
  output logic          busy,
  output logic          wr_valid,
  input  logic          wr_ready,
  output logic [1:0]    wr_kind,
  output logic [AW-1:0] wr_addr,
  output logic          done,
  output logic [CW-1:0] nominal_cycles,
  output logic [SW-1:0] stall_cycles
);
  localparam logic [1:0] LAST_WR = WK_PC_HI;

  seq_state_e    state;
  logic [CW-1:0] cnt;
  logic [1:0]    widx;
  logic [AW-1:0] sp_q;
  logic [CW-1:0] tot_q;
  logic [CW-1:0] off_q;
  logic [CW-1:0] dec_off;
  logic [CW-1:0] dec_total;
  logic          accept;
  logic          stall_now;
  logic          tick_now;
  logic          finish_now;

  exc_class_decode #(.CW(CW)) u_decode (
    .cls    (req_class),
    .ext    (req_ext),
    .offset (dec_off),
    .total  (dec_total)
  );

  assign accept     = req_valid && (state == ST_IDLE);
  assign busy       = (state != ST_IDLE);
  assign wr_valid   = (state == ST_WR);
  assign wr_kind    = widx;
  assign wr_addr    = sp_q - AW'({widx + 2'd1, 1'b0});
  assign stall_now  = wr_valid && !wr_ready;
  assign tick_now   = busy && !stall_now;
  assign finish_now = (state == ST_TAIL) && (cnt == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      cnt   <= '0;
      widx  <= '0;
      sp_q  <= '0;
      tot_q <= '0;
      off_q <= '0;
      done  <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state)
        ST_IDLE: if (accept) begin
          sp_q  <= req_sp;
          tot_q <= dec_total;
          off_q <= dec_off;
          widx  <= WK_PC_LO;
          if (dec_off == '0) begin
            state <= ST_WR;
          end else begin
            state <= ST_PRE;
            cnt   <= dec_off - CW'(1);
          end
        end
        ST_PRE: begin
          if (cnt == '0) state <= ST_WR;
          else           cnt   <= cnt - CW'(1);
        end
        ST_WR: if (wr_ready) begin
          if (widx == LAST_WR) begin
            state <= ST_TAIL;
            cnt   <= tot_q - off_q - CW'(4);
          end else begin
            widx <= widx + 2'd1;
          end
        end
        ST_TAIL: begin
          if (cnt == '0) begin
            state <= ST_IDLE;
            done  <= 1'b1;
          end else begin
            cnt <= cnt - CW'(1);
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  exc_cycle_meter #(.CW(CW), .SW(SW)) u_meter (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (accept),
    .tick    (tick_now),
    .stall   (stall_now),
    .finish  (finish_now),
    .nominal (nominal_cycles),
    .stalls  (stall_cycles)
  );

  // R8
  wr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid && !wr_ready |=> wr_valid && $stable(wr_kind) && $stable(wr_addr));

  // R2
  kind_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(wr_valid && wr_ready) && wr_valid |-> wr_kind == $past(wr_kind) + 2'd1);

  // R9
  done_after_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);

  // R4
  done_total_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> nominal_cycles == tot_q);

  // R7
  hold_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(sp_q) && $stable(tot_q));
endmodule

// File: tb/tb_exc_entry_seq.sv
`timescale 1ns/1ps
module tb_exc_entry_seq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [2:0]  req_class = '0;
  logic        req_ext = 1'b0;
  logic [31:0] req_sp = '0;
  logic        busy;
  logic        wr_valid;
  logic        wr_ready = 1'b0;
  logic [1:0]  wr_kind;
  logic [31:0] wr_addr;
  logic        done;
  logic [7:0]  nominal_cycles;
  logic [15:0] stall_cycles;

  int n_tests = 0;
  int n_fail  = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  exc_entry_seq dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_class(req_class),
    .req_ext(req_ext), .req_sp(req_sp), .busy(busy), .wr_valid(wr_valid),
    .wr_ready(wr_ready), .wr_kind(wr_kind), .wr_addr(wr_addr), .done(done),
    .nominal_cycles(nominal_cycles), .stall_cycles(stall_cycles)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int exp_off(input logic [2:0] c);
    case (c)
      3'd2: return 12;
      3'd3: return 8;
      3'd7: return 0;
      default: return 4;
    endcase
  endfunction

  function automatic int exp_total(input logic [2:0] c, input bit e);
    case (c)
      3'd2: return e ? 134 : 58;
      3'd3: return e ? 130 : 54;
      default: return e ? 38 : 34;
    endcase
  endfunction

  task automatic run_and_check(input logic [2:0] cls, input bit ext,
                               input logic [31:0] sp, input int stall_n,
                               input bit poke, input string tot_req);
    int idle = 0;
    int busy_n = 0;
    int nwr = 0;
    int wait_c = 0;
    bit seen_wr = 1'b0;
    int kinds [3];
    longint addrs [3];
    int eo = exp_off(cls);
    int et = exp_total(cls, ext);
    @(negedge clk);
    req_class = cls; req_ext = ext; req_sp = sp; req_valid = 1'b1; wr_ready = 1'b0;
    @(negedge clk);
    req_valid = 1'b0;
    chk(busy == 1'b1, "R7", "busy after accept", busy, 1);
    while (busy && busy_n < 2000) begin
      busy_n++;
      if (wr_valid) begin
        seen_wr = 1'b1;
        if (wait_c < stall_n) begin
          wr_ready = 1'b0;
          wait_c++;
        end else begin
          wr_ready = 1'b1;
          if (nwr < 3) begin
            kinds[nwr] = int'(wr_kind);
            addrs[nwr] = longint'(wr_addr);
          end
          nwr++;
          wait_c = 0;
        end
      end else begin
        wr_ready = 1'b0;
        if (!seen_wr) idle++;
      end
      if (poke && busy_n == 5) begin
        req_valid = 1'b1; req_class = 3'd4; req_ext = ~ext; req_sp = 32'h0000_9000;
      end
      if (poke && busy_n == 9) req_valid = 1'b0;
      @(negedge clk);
    end
    wr_ready = 1'b0;
    chk(idle == eo, "R1", "idle cycles before first write", idle, eo);
    chk(nwr == 3, "R2", "write count", nwr, 3);
    for (int i = 0; i < 3; i++) begin
      chk(kinds[i] == i, "R2", "write kind order", kinds[i], i);
      chk(addrs[i] == longint'(sp - 32'(2 * (i + 1))), "R3", "write address",
          addrs[i], longint'(sp - 32'(2 * (i + 1))));
    end
    chk(done == 1'b1, "R9", "done after busy falls", done, 1);
    chk(int'(nominal_cycles) == et, tot_req, "nominal cycles", nominal_cycles, et);
    chk(int'(stall_cycles) == 3 * stall_n, "R8", "stall cycles", stall_cycles, 3 * stall_n);
    chk(busy_n == et + 3 * stall_n, "R8", "busy duration", busy_n, et + 3 * stall_n);
    @(negedge clk);
    chk(done == 1'b0, "R9", "done single pulse", done, 0);
    chk(int'(nominal_cycles) == et, "R9", "nominal held", nominal_cycles, et);
    chk(busy == 1'b0, "R7", "no restart after sequence", busy, 0);
  endtask

  task automatic t_reset;
    chk(busy == 1'b0, "R10", "busy at reset", busy, 0);
    chk(wr_valid == 1'b0, "R10", "wr_valid at reset", wr_valid, 0);
    chk(done == 1'b0, "R10", "done at reset", done, 0);
  endtask

  task automatic t_base_classes;
    run_and_check(3'd2, 1'b0, 32'h0000_1000, 0, 1'b0, "R4");
    run_and_check(3'd3, 1'b0, 32'h0000_2002, 0, 1'b0, "R4");
    run_and_check(3'd4, 1'b0, 32'h0000_0100, 0, 1'b0, "R4");
    run_and_check(3'd5, 1'b0, 32'h0001_0000, 0, 1'b0, "R4");
  endtask

  task automatic t_ext_classes;
    run_and_check(3'd2, 1'b1, 32'h0000_3000, 0, 1'b0, "R5");
    run_and_check(3'd3, 1'b1, 32'h0000_4000, 0, 1'b0, "R5");
    run_and_check(3'd5, 1'b1, 32'h0000_5000, 0, 1'b0, "R5");
  endtask

  task automatic t_default_classes;
    run_and_check(3'd7, 1'b0, 32'h0000_6000, 0, 1'b0, "R6");
    run_and_check(3'd6, 1'b0, 32'h0000_7000, 0, 1'b0, "R6");
    run_and_check(3'd0, 1'b1, 32'h0000_0006, 0, 1'b0, "R6");
    run_and_check(3'd1, 1'b1, 32'h0000_8000, 0, 1'b0, "R6");
  endtask

  task automatic t_stall;
    run_and_check(3'd3, 1'b0, 32'h0000_A000, 2, 1'b0, "R4");
    run_and_check(3'd7, 1'b1, 32'h0000_B000, 5, 1'b0, "R6");
  endtask

  task automatic t_holdoff;
    run_and_check(3'd2, 1'b0, 32'h0000_C000, 1, 1'b1, "R4");
  endtask

  initial begin
    #(5.0 * 150000);
    if (!finished) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_base_classes();
    t_ext_classes();
    t_default_classes();
    t_stall();
    t_holdoff();
    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule